// File: doc/BRIEF.md
# Secure-Routing Interrupt Controller

This block gathers 128 level-sensitive interrupt sources and drives two processor request lines: a normal request (`irqOut`) and a fast request (`fiqOut`). Software reaches it through a simple 32-bit register bus. Sources sit in four banks of 32, and source n is bit n&31 of bank n>>5. Each source has an enable bit, a routing bit and an 8-bit priority, where 0 is the most urgent. A global threshold and a control word decide whether anything reaches the processor.

Enable bits are never written directly. One register per bank sets bits and a companion register clears them, so several agents can change enables without a read-modify-write. Each cycle the block forms a pending vector, which is each input ANDed with its enable. It keeps the pending sources whose priority is below the threshold and splits the survivors by routing bit. The two request lines are registered and follow with one clock of delay.

Top module: `irq_route_ctrl`

## Requirements
- R1: A write to the set register of bank b (byte offset 0x100+4b) sets every enable bit written as 1 and leaves the bits written as 0 unchanged. Reading offset 0x100+4b or 0x180+4b returns the enable bits of bank b.
- R2: A write to the clear register of bank b (offset 0x180+4b) clears every enable bit written as 1 and leaves the other bits unchanged.
- R3: The pending word at offset 0xD80+4b reads (input AND enable) for bank b. The threshold and the control word have no effect on it.
- R4: The priority of source n is bits [8*(n&3)+7 : 8*(n&3)] of the read/write word at offset 0x400+4*(n>>2). The threshold is the low 8 bits of offset 0x004.
- R5: A pending source counts toward an output only if its priority is numerically less than the threshold. A threshold of 0 blocks every source, and a threshold of 0xFF passes priorities 0 to 0xFE.
- R6: The routing word of bank b is at offset 0x080+4b. A routing bit of 1 sends the source to `irqOut`, and a routing bit of 0 sends it to `fiqOut`.
- R7: In the control word at offset 0x000, bit 0 is the controller enable and gates both outputs. Bit 1 is the non-secure enable and gates `irqOut` only. A write updates bit 1 only when bit 2 of the written data is 1. Bit 2 always reads 0.
- R8: `irqOut` and `fiqOut` are registered. They change on the first clock edge after the change in an input or register that causes them.
- R9: After reset all enables, routing bits, priorities, the threshold and the control word are 0, and both outputs are low.
- R10: The word at offset 0x008 is plain 32-bit read/write storage and has no effect on the outputs.
- R11: Unmapped or misaligned addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| irqIn | input | 128 | Synchronous level interrupt inputs |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
The delivery path is tried with sources that are asserted but disabled, enabled and routed each way, and blocked by priority exactly at the threshold and just below it. These cases separate a less-than compare from a less-or-equal compare, and a routing inversion from a gating fault. The control word is written with and without its write-mask bit, which shows whether the non-secure enable is protected. It also shows that the controller enable stops the fast line while the non-secure enable does not. Each output is sampled in the cycle before its edge and in the cycle after, which exposes a missing or extra register stage.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
  localparam int IDX_W = 8;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTRL, RD_MASK, RD_SYNC, RD_SEC, RD_EN, RD_PRIO, RD_PEND
  } rdSel_e;

  typedef struct packed {
    logic             wrCtrl;
    logic             wrMask;
    logic             wrSync;
    logic             wrSec;
    logic             wrEnSet;
    logic             wrEnClr;
    logic             wrPrio;
    logic [IDX_W-1:0] regIdx;
    rdSel_e           rdSel;
  } regStrobe_t;
endpackage

// File: rtl/irq_route_decode.sv
`timescale 1ns/1ps
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int NUM_BANKS     = 4,
  parameter int NUM_PRIO_REGS = 32
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        stb
);
  localparam logic [ADDR_W-1:0] CTRL_OFF  = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] MASK_OFF  = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] SYNC_OFF  = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] SEC_BASE  = ADDR_W'(12'h080);
  localparam logic [ADDR_W-1:0] SET_BASE  = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] CLR_BASE  = ADDR_W'(12'h180);
  localparam logic [ADDR_W-1:0] PRIO_BASE = ADDR_W'(12'h400);
  localparam logic [ADDR_W-1:0] PEND_BASE = ADDR_W'(12'hD80);

  function automatic logic inWin(input logic [ADDR_W-1:0] a,
                                 input logic [ADDR_W-1:0] base,
                                 input int cnt);
    return (a >= base) && (a < base + ADDR_W'(4 * cnt));
  endfunction

  function automatic logic [IDX_W-1:0] wordIdx(input logic [ADDR_W-1:0] a,
                                               input logic [ADDR_W-1:0] base);
    return IDX_W'((a - base) >> 2);
  endfunction

  logic access;
  logic doWrite;

  assign access  = busSel && (busAddr[1:0] == 2'b00);
  assign doWrite = access && busWrite;

  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    if (access) begin
      if (busAddr == CTRL_OFF) begin
        stb.rdSel  = RD_CTRL;
        stb.wrCtrl = doWrite;
      end else if (busAddr == MASK_OFF) begin
        stb.rdSel  = RD_MASK;
        stb.wrMask = doWrite;
      end else if (busAddr == SYNC_OFF) begin
        stb.rdSel  = RD_SYNC;
        stb.wrSync = doWrite;
      end else if (inWin(busAddr, SEC_BASE, NUM_BANKS)) begin
        stb.rdSel  = RD_SEC;
        stb.wrSec  = doWrite;
        stb.regIdx = wordIdx(busAddr, SEC_BASE);
      end else if (inWin(busAddr, SET_BASE, NUM_BANKS)) begin
        stb.rdSel   = RD_EN;
        stb.wrEnSet = doWrite;
        stb.regIdx  = wordIdx(busAddr, SET_BASE);
      end else if (inWin(busAddr, CLR_BASE, NUM_BANKS)) begin
        stb.rdSel   = RD_EN;
        stb.wrEnClr = doWrite;
        stb.regIdx  = wordIdx(busAddr, CLR_BASE);
      end else if (inWin(busAddr, PRIO_BASE, NUM_PRIO_REGS)) begin
        stb.rdSel  = RD_PRIO;
        stb.wrPrio = doWrite;
        stb.regIdx = wordIdx(busAddr, PRIO_BASE);
      end else if (inWin(busAddr, PEND_BASE, NUM_BANKS)) begin
        stb.rdSel  = RD_PEND;
        stb.regIdx = wordIdx(busAddr, PEND_BASE);
      end
    end
  end
endmodule

// File: rtl/irq_route_regs.sv
`timescale 1ns/1ps
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int PRIO_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  regStrobe_t                stb,
  input  logic [DATA_W-1:0]         busWdata,
  input  logic [NUM_SRC-1:0]        pendVec,
  output logic [DATA_W-1:0]         busRdata,
  output logic [NUM_SRC-1:0]        enVec,
  output logic [NUM_SRC-1:0]        secVec,
  output logic [NUM_SRC*PRIO_W-1:0] prioVec,
  output logic [PRIO_W-1:0]         maskReg,
  output logic                      ctrlEn,
  output logic                      nsEn
);
  localparam int NUM_BANKS     = NUM_SRC / DATA_W;
  localparam int NUM_PRIO_REGS = NUM_SRC * PRIO_W / DATA_W;

  logic [DATA_W-1:0] syncReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlEn  <= 1'b0;
      nsEn    <= 1'b0;
      maskReg <= '0;
      syncReg <= '0;
      enVec   <= '0;
      secVec  <= '0;
      prioVec <= '0;
    end else begin
      if (stb.wrCtrl) begin
        ctrlEn <= busWdata[0];
        if (busWdata[2]) nsEn <= busWdata[1];
      end
      if (stb.wrMask) maskReg <= busWdata[PRIO_W-1:0];
      if (stb.wrSync) syncReg <= busWdata;
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (stb.regIdx == IDX_W'(b)) begin
          if (stb.wrSec)
            secVec[b*DATA_W +: DATA_W] <= busWdata;
          if (stb.wrEnSet)
            enVec[b*DATA_W +: DATA_W] <= enVec[b*DATA_W +: DATA_W] | busWdata;
          else if (stb.wrEnClr)
            enVec[b*DATA_W +: DATA_W] <= enVec[b*DATA_W +: DATA_W] & ~busWdata;
        end
      end
      for (int r = 0; r < NUM_PRIO_REGS; r++) begin
        if (stb.wrPrio && stb.regIdx == IDX_W'(r))
          prioVec[r*DATA_W +: DATA_W] <= busWdata;
      end
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (stb.rdSel)
      RD_CTRL: busRdata = DATA_W'({nsEn, ctrlEn});
      RD_MASK: busRdata = DATA_W'(maskReg);
      RD_SYNC: busRdata = syncReg;
      RD_SEC, RD_EN, RD_PEND: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (stb.regIdx == IDX_W'(b)) begin
            if (stb.rdSel == RD_SEC)     busRdata = secVec[b*DATA_W +: DATA_W];
            else if (stb.rdSel == RD_EN) busRdata = enVec[b*DATA_W +: DATA_W];
            else                         busRdata = pendVec[b*DATA_W +: DATA_W];
          end
        end
      end
      RD_PRIO: begin
        for (int r = 0; r < NUM_PRIO_REGS; r++) begin
          if (stb.regIdx == IDX_W'(r)) busRdata = prioVec[r*DATA_W +: DATA_W];
        end
      end
      default: busRdata = '0;
    endcase
  end

  for (genvar gb = 0; gb < NUM_BANKS; gb++) begin : g_enChk
    // R1
    en_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stb.wrEnSet && stb.regIdx == IDX_W'(gb)) |=>
        ((enVec[gb*DATA_W +: DATA_W] & $past(busWdata)) == $past(busWdata)));
    // R2
    en_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
      (stb.wrEnClr && stb.regIdx == IDX_W'(gb)) |=>
        ((enVec[gb*DATA_W +: DATA_W] & $past(busWdata)) == '0));
    // R1
    en_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      ((stb.wrEnSet || stb.wrEnClr) && stb.regIdx == IDX_W'(gb)) |=>
        ((enVec[gb*DATA_W +: DATA_W] & ~$past(busWdata)) ==
         ($past(enVec[gb*DATA_W +: DATA_W]) & ~$past(busWdata))));
  end
endmodule

// File: rtl/irq_route_deliver.sv
`timescale 1ns/1ps
module irq_route_deliver #(
  parameter int NUM_SRC = 128,
  parameter int PRIO_W  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        irqIn,
  input  logic [NUM_SRC-1:0]        enVec,
  input  logic [NUM_SRC-1:0]        secVec,
  input  logic [NUM_SRC*PRIO_W-1:0] prioVec,
  input  logic [PRIO_W-1:0]         maskReg,
  input  logic                      ctrlEn,
  input  logic                      nsEn,
  output logic [NUM_SRC-1:0]        pendVec,
  output logic                      irqOut,
  output logic                      fiqOut
);
  logic [NUM_SRC-1:0] passVec;
  logic               irqHit;
  logic               fiqHit;

  assign pendVec = irqIn & enVec;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign passVec[s] = pendVec[s] && (prioVec[s*PRIO_W +: PRIO_W] < maskReg);
  end

  assign irqHit = |(passVec & secVec);
  assign fiqHit = |(passVec & ~secVec);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqOut <= 1'b0;
      fiqOut <= 1'b0;
    end else begin
      irqOut <= ctrlEn && nsEn && irqHit;
      fiqOut <= ctrlEn && fiqHit;
    end
  end

  // R5
  mask_zero_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == '0) |=> (!irqOut && !fiqOut));
  // R7
  ctrl_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlEn |=> (!irqOut && !fiqOut));
  // R7
  ns_gate_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nsEn |=> !irqOut);
endmodule

// File: rtl/irq_route_ctrl.sv
`timescale 1ns/1ps
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC = 128,
  parameter int PRIO_W  = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic               irqOut,
  output logic               fiqOut
);
  localparam int NUM_BANKS     = NUM_SRC / DATA_W;
  localparam int NUM_PRIO_REGS = NUM_SRC * PRIO_W / DATA_W;

  regStrobe_t                stb;
  logic [NUM_SRC-1:0]        enVec;
  logic [NUM_SRC-1:0]        secVec;
  logic [NUM_SRC-1:0]        pendVec;
  logic [NUM_SRC*PRIO_W-1:0] prioVec;
  logic [PRIO_W-1:0]         maskReg;
  logic                      ctrlEn;
  logic                      nsEn;

  irq_route_decode #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .NUM_PRIO_REGS(NUM_PRIO_REGS)
  ) u_decode (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr), .stb(stb)
  );

  irq_route_regs #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rstN(rstN), .stb(stb), .busWdata(busWdata),
    .pendVec(pendVec), .busRdata(busRdata), .enVec(enVec), .secVec(secVec),
    .prioVec(prioVec), .maskReg(maskReg), .ctrlEn(ctrlEn), .nsEn(nsEn)
  );

  irq_route_deliver #(
    .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)
  ) u_deliver (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .enVec(enVec), .secVec(secVec),
    .prioVec(prioVec), .maskReg(maskReg), .ctrlEn(ctrlEn), .nsEn(nsEn),
    .pendVec(pendVec), .irqOut(irqOut), .fiqOut(fiqOut)
  );
endmodule

// File: tb/irq_route_ctrl_tb.sv
`timescale 1ns/1ps
module irq_route_ctrl_tb;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busSel = 1'b0;
  logic         busWrite = 1'b0;
  logic [11:0]  busAddr = '0;
  logic [31:0]  busWdata = '0;
  logic [31:0]  busRdata;
  logic [127:0] irqIn = '0;
  logic         irqOut;
  logic         fiqOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    bit          isOut;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  irq_route_ctrl u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqIn(irqIn), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  // monitor: pops expected items and compares them away from the edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = q.pop_front();
        got = it.isOut ? {30'b0, irqOut, fiqOut} : busRdata;
        checks++;
        if (got !== it.exp) begin
          fails++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic busWr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic expRead(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    it.isOut = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic expOutNow(input bit irqE, input bit fiqE, input string tag);
    item_t it;
    it.isOut = 1'b1; it.exp = {30'b0, irqE, fiqE}; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic expOut(input bit irqE, input bit fiqE, input string tag);
    @(negedge clk);
    expOutNow(irqE, fiqE, tag);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R9 reset state
    expOut(1'b0, 1'b0, "R9 outputs low");
    expRead(12'h000, 32'h0, "R9 control");
    expRead(12'h004, 32'h0, "R9 mask");
    expRead(12'h084, 32'h0, "R9 routing");
    expRead(12'h104, 32'h0, "R9 enable");
    expRead(12'h424, 32'h0, "R9 priority");

    // R10 sync storage
    busWr(12'h008, 32'hA5A5_1234);
    expRead(12'h008, 32'hA5A5_1234, "R10 readback");
    expOut(1'b0, 1'b0, "R10 no effect");

    // R11 unmapped and misaligned
    busWr(12'h200, 32'hFFFF_FFFF);
    expRead(12'h200, 32'h0, "R11 unmapped reads 0");
    busWr(12'h106, 32'hFFFF_FFFF);
    expRead(12'h104, 32'h0, "R11 misaligned write ignored");

    // R1 set, readback at both addresses
    busWr(12'h104, 32'h0000_00F0);
    expRead(12'h104, 32'h0000_00F0, "R1 set");
    expRead(12'h184, 32'h0000_00F0, "R1 readback at clear offset");
    busWr(12'h104, 32'h0000_0100);
    expRead(12'h104, 32'h0000_01F0, "R1 zero bits kept");

    // R2 clear
    busWr(12'h184, 32'h0000_0030);
    expRead(12'h104, 32'h0000_01C0, "R2 clear");

    // R3 pending with mask 0 and controller off
    @(negedge clk);
    irqIn[38] = 1'b1; irqIn[40] = 1'b1; irqIn[3] = 1'b1;
    expRead(12'hD84, 32'h0000_0140, "R3 pending bank1");
    expRead(12'hD80, 32'h0, "R3 disabled not pending");
    expOut(1'b0, 1'b0, "R7 controller off");

    // R5 mask 0 blocks with controller on
    busWr(12'h000, 32'h1);
    expOut(1'b0, 1'b0, "R5 mask zero blocks");
    busWr(12'h004, 32'hFF);
    expRead(12'h004, 32'hFF, "R4 mask readback");
    expOut(1'b0, 1'b1, "R6 routing 0 to fast line");

    // R6/R7 routing to normal line, gated by non-secure enable
    busWr(12'h084, 32'h0000_0140);
    expOut(1'b0, 1'b0, "R7 non-secure disabled");
    busWr(12'h000, 32'h3);
    expRead(12'h000, 32'h1, "R7 write-mask protects bit1");
    expOut(1'b0, 1'b0, "R7 still gated");
    busWr(12'h000, 32'h7);
    expRead(12'h000, 32'h3, "R7 bit2 reads 0");
    expOut(1'b1, 1'b0, "R6 routing 1 to normal line");
    busWr(12'h084, 32'h0000_0040);
    expOut(1'b1, 1'b1, "R6 split routing");

    // R4/R5 priority versus threshold
    busWr(12'h424, 32'h0080_0000);
    expRead(12'h424, 32'h0080_0000, "R4 priority readback");
    busWr(12'h004, 32'h80);
    expOut(1'b0, 1'b1, "R5 equal to threshold blocked");
    busWr(12'h004, 32'h81);
    expOut(1'b1, 1'b1, "R5 below threshold passes");
    busWr(12'h424, 32'h00FE_0000);
    busWr(12'h004, 32'hFF);
    expOut(1'b1, 1'b1, "R5 0xFE passes at 0xFF");
    busWr(12'h424, 32'h00FF_0000);
    expOut(1'b0, 1'b1, "R5 0xFF blocked at 0xFF");

    // R8 one-cycle latency
    @(negedge clk);
    irqIn[40] = 1'b0;
    expOutNow(1'b0, 1'b1, "R8 before edge");
    expOut(1'b0, 1'b0, "R8 after edge");
    expRead(12'hD84, 32'h0000_0040, "R3 pending follows input");

    // R3/R2 bank0 source
    busWr(12'h100, 32'h8);
    expRead(12'hD80, 32'h8, "R3 enabled source pending");
    expOut(1'b0, 1'b1, "R6 bank0 to fast line");
    busWr(12'h180, 32'h8);
    expOut(1'b0, 1'b0, "R2 clear stops delivery");

    // R7 controller enable gates both lines, non-secure bit kept
    busWr(12'h424, 32'h0);
    expOut(1'b1, 1'b0, "R4 priority lowered");
    busWr(12'h000, 32'h0);
    expOut(1'b0, 1'b0, "R7 controller disable");
    expRead(12'h000, 32'h2, "R7 non-secure kept");
    busWr(12'h000, 32'h1);
    expOut(1'b1, 1'b0, "R7 controller re-enable");
    busWr(12'h004, 32'h0);
    expOut(1'b0, 1'b0, "R5 mask zero again");

    repeat (3) @(negedge clk);
    done = 1'b1;
    finishRun();
  end
endmodule